// File: doc/BRIEF.md
# Program-Step Data Capture Unit

This block watches the step counter of a sequential DSP program and, when the counter reaches a step chosen in software, copies one of four datapath values into a capture slot. The four values are the multiplier result, the decibel converter result, the multiplier data operand and the multiplier coefficient operand. There are four independent slots. Each slot is set up by an 11-bit word that holds a 9-bit step index in bits 10:2 and a 2-bit source select in bits 1:0.

Two slots are read back through a simple register port. The other two drive the left and right words of a serial output formatter that lies outside this block. The program counter arrives as a valid-only strobe. The block samples every valid step in the cycle it is presented, so it never exerts back-pressure and needs no ready signal. Captured values are held in 24-bit registers. The 22-bit coefficient operand is sign-extended into those registers.

Top module: `pstep_capture`

## Requirements
- R1: After reset every slot holds zero and every setup word is zero (step 0, select 00), so all read data and both serial words read zero.
- R2: A write with cfg_wr high to address 261, 262, 263 or 264 stores cfg_wdata as the setup word of slot 0, 1, 2 or 3 on that clock edge. Reading 263 or 264 returns the setup word of slot 2 or 3, zero-extended to 24 bits.
- R3: When step_valid is high and step_idx equals a slot's step index, and its select is 00, the slot loads mul_out at that edge, and the new value is visible in the following cycle.
- R4: Under the same match, select 01 loads db_out.
- R5: Under the same match, select 10 loads mul_din.
- R6: Under the same match, select 11 loads mul_coef sign-extended from 22 to 24 bits. For example, 22'h100000 (a gain of 1.0) reads as 24'h100000 and 22'h200001 reads as 24'hE00001.
- R7: A slot keeps its value on any cycle where step_valid is low or step_idx differs from its step index.
- R8: Reading 261 or 262 returns the captured value of slot 0 or 1. Slot 2 drives ser_left and slot 3 drives ser_right. Any other read address returns zero.
- R9: A write to an address outside 261..264 changes no setup word.
- R10: Slots are independent. Several slots that share a step index all capture on the same match, each from its own source, and step 511 is matched like any other step.
- R11: A setup write on the same edge as a step match does not affect that capture. The capture uses the setup word that was in place before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_valid | input | 1 | Program step strobe; step_idx is sampled when high |
| step_idx | input | 9 | Current program step |
| mul_out | input | 24 | Multiplier result, 1.23 |
| db_out | input | 24 | Decibel converter result |
| mul_din | input | 24 | Multiplier data operand, 3.21 |
| mul_coef | input | 22 | Multiplier coefficient operand, 2.20 |
| cfg_wr | input | 1 | Setup write enable |
| cfg_addr | input | 9 | Register address for write and read |
| cfg_wdata | input | 11 | Setup word {step[8:0], select[1:0]} |
| cfg_rdata | output | 24 | Read data for cfg_addr (combinational) |
| ser_left | output | 24 | Slot 2 value for the serial left word |
| ser_right | output | 24 | Slot 3 value for the serial right word |

## Verification
The assertions assume that the source buses present the value belonging to step_idx in the same cycle that step_valid is high, and that cfg_wdata is meaningful only while cfg_wr is high. They also assume that the step counter may repeat or skip steps freely. The bench drives every input only at the falling edge and holds each source bus steady across the capturing edge. It raises step_valid for one cycle per step and sets up slot step indices so that only the intended slots match, except where R10 deliberately shares a step between slots.

// File: rtl/pstep_cap_pkg.sv
package pstep_cap_pkg;
  localparam int PC_W    = 9;
  localparam int SEL_W   = 2;
  localparam int SETUP_W = PC_W + SEL_W;
  localparam int DATA_W  = 24;
  localparam int COEF_W  = 22;
  localparam int NUM_CAP = 4;
  localparam int NUM_RD  = 2;

  typedef enum logic [SEL_W-1:0] {
    SRC_MUL  = 2'b00,
    SRC_DB   = 2'b01,
    SRC_DIN  = 2'b10,
    SRC_COEF = 2'b11
  } src_sel_e;

  function automatic logic [DATA_W-1:0] widen_coef(input logic [COEF_W-1:0] c);
    return {{(DATA_W-COEF_W){c[COEF_W-1]}}, c};
  endfunction
endpackage

// File: rtl/pstep_cap_slot.sv
module pstep_cap_slot
  import pstep_cap_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_valid,
  input  logic [PC_W-1:0]    step_idx,
  input  logic [SETUP_W-1:0] setup,
  input  logic [DATA_W-1:0]  mul_out,
  input  logic [DATA_W-1:0]  db_out,
  input  logic [DATA_W-1:0]  mul_din,
  input  logic [COEF_W-1:0]  mul_coef,
  output logic [DATA_W-1:0]  cap_q
);
  logic [PC_W-1:0] trig_step;
  src_sel_e        sel;
  logic            hit;
  logic [DATA_W-1:0] pick;

  assign trig_step = setup[SETUP_W-1:SEL_W];
  assign sel       = src_sel_e'(setup[SEL_W-1:0]);
  assign hit       = step_valid && (step_idx == trig_step);

  always_comb begin
    unique case (sel)
      SRC_MUL:  pick = mul_out;
      SRC_DB:   pick = db_out;
      SRC_DIN:  pick = mul_din;
      default:  pick = widen_coef(mul_coef);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   cap_q <= '0;
    else if (hit) cap_q <= pick;
  end

  p_mulout_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && step_idx == setup[SETUP_W-1:SEL_W] && setup[SEL_W-1:0] == 2'b00)
    |=> cap_q == $past(mul_out));
  p_dbout_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && step_idx == setup[SETUP_W-1:SEL_W] && setup[SEL_W-1:0] == 2'b01)
    |=> cap_q == $past(db_out));
  p_din_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && step_idx == setup[SETUP_W-1:SEL_W] && setup[SEL_W-1:0] == 2'b10)
    |=> cap_q == $past(mul_din));
  p_coef_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && step_idx == setup[SETUP_W-1:SEL_W] && setup[SEL_W-1:0] == 2'b11)
    |=> (cap_q[COEF_W-1:0] == $past(mul_coef)) && (cap_q[DATA_W-1] == $past(mul_coef[COEF_W-1])));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_valid && step_idx == setup[SETUP_W-1:SEL_W]) |=> $stable(cap_q));
endmodule

// File: rtl/pstep_cap_regs.sv
module pstep_cap_regs
  import pstep_cap_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int BASE_ADDR = 261
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_wr,
  input  logic [ADDR_W-1:0]                 cfg_addr,
  input  logic [SETUP_W-1:0]                cfg_wdata,
  input  logic [NUM_CAP-1:0][DATA_W-1:0]    caps,
  output logic [NUM_CAP-1:0][SETUP_W-1:0]   setups,
  output logic [DATA_W-1:0]                 cfg_rdata
);
  localparam int LAST_ADDR = BASE_ADDR + NUM_CAP - 1;

  logic in_range;
  assign in_range = (cfg_addr >= ADDR_W'(BASE_ADDR)) && (cfg_addr <= ADDR_W'(LAST_ADDR));

  for (genvar i = 0; i < NUM_CAP; i++) begin : g_setup
    logic sel_me;
    assign sel_me = cfg_wr && (cfg_addr == ADDR_W'(BASE_ADDR + i));
    always_ff @(posedge clk) begin
      if (!rst_n)      setups[i] <= '0;
      else if (sel_me) setups[i] <= cfg_wdata;
    end
    p_setup_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_addr == ADDR_W'(BASE_ADDR + i)) |=> setups[i] == $past(cfg_wdata));
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_CAP; i++) begin
      if (cfg_addr == ADDR_W'(BASE_ADDR + i)) begin
        if (i < NUM_RD) cfg_rdata = caps[i];
        else            cfg_rdata = {{(DATA_W-SETUP_W){1'b0}}, setups[i]};
      end
    end
  end

  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !in_range) |=> $stable(setups));
  p_nodata_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_range |-> cfg_rdata == '0);
endmodule

// File: rtl/pstep_capture.sv
module pstep_capture
  import pstep_cap_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int BASE_ADDR = 261
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_valid,
  input  logic [PC_W-1:0]     step_idx,
  input  logic [DATA_W-1:0]   mul_out,
  input  logic [DATA_W-1:0]   db_out,
  input  logic [DATA_W-1:0]   mul_din,
  input  logic [COEF_W-1:0]   mul_coef,
  input  logic                cfg_wr,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [SETUP_W-1:0]  cfg_wdata,
  output logic [DATA_W-1:0]   cfg_rdata,
  output logic [DATA_W-1:0]   ser_left,
  output logic [DATA_W-1:0]   ser_right
);
  logic [NUM_CAP-1:0][DATA_W-1:0]  caps;
  logic [NUM_CAP-1:0][SETUP_W-1:0] setups;

  pstep_cap_regs #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .caps      (caps),
    .setups    (setups),
    .cfg_rdata (cfg_rdata)
  );

  for (genvar i = 0; i < NUM_CAP; i++) begin : g_slot
    pstep_cap_slot u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_valid (step_valid),
      .step_idx   (step_idx),
      .setup      (setups[i]),
      .mul_out    (mul_out),
      .db_out     (db_out),
      .mul_din    (mul_din),
      .mul_coef   (mul_coef),
      .cap_q      (caps[i])
    );
  end

  assign ser_left  = caps[NUM_RD];
  assign ser_right = caps[NUM_RD+1];

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (ser_left == '0 && ser_right == '0));
endmodule

// File: tb/pstep_capture_bench.sv
module pstep_capture_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_valid = 1'b0;
  logic [8:0]  step_idx = '0;
  logic [23:0] mul_out = '0, db_out = '0, mul_din = '0;
  logic [21:0] mul_coef = '0;
  logic        cfg_wr = 1'b0;
  logic [8:0]  cfg_addr = '0;
  logic [10:0] cfg_wdata = '0;
  logic [23:0] cfg_rdata, ser_left, ser_right;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pstep_capture u_pstep_capture (
    .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .step_idx(step_idx),
    .mul_out(mul_out), .db_out(db_out), .mul_din(mul_din), .mul_coef(mul_coef),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .ser_left(ser_left), .ser_right(ser_right)
  );

  typedef struct packed {
    logic [1:0]  slot;
    logic [8:0]  step;
    logic [1:0]  sel;
    logic [23:0] mo;
    logic [23:0] db;
    logic [23:0] di;
    logic [21:0] co;
    logic [23:0] exp_v;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd0, 9'd5,   2'd0, 24'h123456, 24'h0000AA, 24'h000BBB, 22'h000CCC, 24'h123456},
    '{2'd1, 9'd17,  2'd1, 24'h111111, 24'hABCDEF, 24'h222222, 22'h033333, 24'hABCDEF},
    '{2'd2, 9'd100, 2'd2, 24'h444444, 24'h555555, 24'h800001, 22'h066666, 24'h800001},
    '{2'd3, 9'd511, 2'd3, 24'h777777, 24'h888888, 24'h999999, 22'h100000, 24'h100000},
    '{2'd0, 9'd0,   2'd3, 24'h0A0A0A, 24'h0B0B0B, 24'h0C0C0C, 22'h200001, 24'hE00001},
    '{2'd1, 9'd300, 2'd2, 24'h010101, 24'h020202, 24'h7FFFFF, 22'h030303, 24'h7FFFFF},
    '{2'd2, 9'd42,  2'd1, 24'h0D0D0D, 24'hFEDCBA, 24'h0E0E0E, 22'h0F0F0F, 24'hFEDCBA},
    '{2'd3, 9'd7,   2'd0, 24'h00C0DE, 24'h0F0F0F, 24'h0E0E0E, 22'h0D0D0D, 24'h00C0DE}
  };

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp_v);
    n_run++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp_v);
    end
  endtask

  task automatic wr_setup(input logic [8:0] addr, input logic [10:0] w);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = addr; cfg_wdata = w;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic do_step(input logic [8:0] pc);
    @(negedge clk);
    step_valid = 1'b1; step_idx = pc;
    @(negedge clk);
    step_valid = 1'b0;
  endtask

  task automatic read_slot(input logic [1:0] s, output logic [23:0] v);
    case (s)
      2'd0: begin cfg_addr = 9'd261; #1; v = cfg_rdata; end
      2'd1: begin cfg_addr = 9'd262; #1; v = cfg_rdata; end
      2'd2: v = ser_left;
      default: v = ser_right;
    endcase
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    cfg_addr = 9'd261; #1; check("R1 slot0", cfg_rdata, 24'h0);
    cfg_addr = 9'd263; #1; check("R1 setup2", cfg_rdata, 24'h0);
    check("R1 ser_left", ser_left, 24'h0);
    check("R1 ser_right", ser_right, 24'h0);

    // Vector table: R3 R4 R5 R6 R8 R10 (step 511)
    for (int k = 0; k < 8; k++) begin
      wr_setup(9'd261 + 9'(VEC[k].slot), {VEC[k].step, VEC[k].sel});
      mul_out = VEC[k].mo; db_out = VEC[k].db; mul_din = VEC[k].di; mul_coef = VEC[k].co;
      do_step(VEC[k].step);
      read_slot(VEC[k].slot, v);
      check($sformatf("R3/R4/R5/R6 vector %0d", k), v, VEC[k].exp_v);
    end

    // R2 setup readback of slots 2 and 3
    @(negedge clk);
    cfg_addr = 9'd263; #1; check("R2 readback 263", cfg_rdata, {13'd0, 9'd42, 2'd1});
    cfg_addr = 9'd264; #1; check("R2 readback 264", cfg_rdata, {13'd0, 9'd7, 2'd0});

    // R8 unmapped read returns zero
    cfg_addr = 9'd265; #1; check("R8 unmapped read", cfg_rdata, 24'h0);

    // R9 write outside range ignored
    wr_setup(9'd260, 11'h7FF);
    wr_setup(9'd265, 11'h7FF);
    cfg_addr = 9'd263; #1; check("R9 setup2 unchanged", cfg_rdata, {13'd0, 9'd42, 2'd1});
    cfg_addr = 9'd264; #1; check("R9 setup3 unchanged", cfg_rdata, {13'd0, 9'd7, 2'd0});

    // R7 hold: matching pc without valid, valid with other pc
    mul_out = 24'h5A5A5A; db_out = 24'h5A5A5A; mul_din = 24'h5A5A5A; mul_coef = 22'h1A5A5A;
    @(negedge clk); step_idx = 9'd42; step_valid = 1'b0;
    @(negedge clk);
    check("R7 hold no valid", ser_left, 24'hFEDCBA);
    do_step(9'd43);
    check("R7 hold other step", ser_left, 24'hFEDCBA);
    check("R7 hold slot3", ser_right, 24'h00C0DE);

    // R10 shared step across slots
    wr_setup(9'd261, {9'd50, 2'd0});
    wr_setup(9'd262, {9'd50, 2'd1});
    wr_setup(9'd263, {9'd50, 2'd2});
    mul_out = 24'h000111; db_out = 24'h000222; mul_din = 24'h000333;
    do_step(9'd50);
    read_slot(2'd0, v); check("R10 shared slot0", v, 24'h000111);
    read_slot(2'd1, v); check("R10 shared slot1", v, 24'h000222);
    check("R10 shared slot2", ser_left, 24'h000333);
    check("R10 slot3 untouched", ser_right, 24'h00C0DE);

    // R11 setup write at the same edge as a match uses the old setup
    wr_setup(9'd261, {9'd60, 2'd0});
    mul_out = 24'h00AAAA; db_out = 24'h00BBBB;
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 9'd261; cfg_wdata = {9'd61, 2'd1};
    step_valid = 1'b1; step_idx = 9'd60;
    @(negedge clk);
    cfg_wr = 1'b0; step_valid = 1'b0;
    read_slot(2'd0, v); check("R11 old setup used", v, 24'h00AAAA);
    do_step(9'd61);
    read_slot(2'd0, v); check("R11 new setup active", v, 24'h00BBBB);

    // R1 reset again clears
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    read_slot(2'd0, v); check("R1 slot0 after reset", v, 24'h0);
    check("R1 ser_left after reset", ser_left, 24'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule